// File: doc/BRIEF.md
# Two-Descriptor Transmit DMA Sequencer

This block feeds a serial transmitter from memory through two descriptors that the CPU loads and that take turns. Each descriptor holds a buffer base address, a byte count and a status byte. The status byte carries an ownership flag, an end-of-frame flag and a per-buffer interrupt flag. When the channel is enabled, the sequencer waits until the CPU hands over the current descriptor by setting its ownership flag. It then reads the buffer byte by byte through a valid/ready memory port and pushes each byte into the transmit FIFO. At the end it clears the ownership flag and moves to the other descriptor.

The sequencer never skips a descriptor. A next-buffer output tells software which descriptor comes next. A frame may run over several buffers. The FIFO push carries an end-of-frame marker, and the framer gets a CRC-append request only after the last byte of a buffer that has the end-of-frame flag set. Two interrupts are produced. A buffer-done pulse fires once per buffer when its last byte is fetched, and only if that buffer's own interrupt flag is set. A transmit-empty level is raised while nothing is left to send.

Top module: `txDmaSeq`

## Requirements
- R1: After reset both status bytes read zero, `nextBuf` is 0 (0 = descriptor A, 1 = B), and `memValid`, `fifoPush`, `crcReq`, `bufDoneIrq` and `txEmptyIrq` are low.
- R2: While the current descriptor's ownership flag (status bit 7) is clear, no memory read is issued, even if the other descriptor is owned.
- R3: An owned descriptor with a nonzero count N is fetched from addresses base, base+1, …, base+N-1 in that order. Each byte is pushed to the FIFO (`fifoPush`, `fifoData` = `memData`) in the same cycle that `memValid` and `memReady` are both high.
- R4: `memValid` stays low in every cycle in which `fifoFull` is high.
- R5: On the cycle after the last byte is pushed, the descriptor's ownership flag reads clear and `nextBuf` has switched to the other descriptor. Service strictly alternates A, B, A, B.
- R6: A CPU write to any field of a descriptor whose ownership flag is set has no effect. Field select: 0 = address, 1 = count, 2 = status.
- R7: `fifoEof` is high with the last byte of a buffer whose status bit 1 is set. `crcReq` pulses for one cycle on the following cycle. Buffers without that bit give neither signal.
- R8: `bufDoneIrq` pulses for one cycle, on the cycle after a buffer's last byte is pushed, exactly when `ienBufDone` is high and the buffer's status bit 0 is set.
- R9: `txEmptyIrq` is high one cycle after a cycle in which the channel is enabled, the sequencer is waiting for ownership, `txLineIdle` is high and `ienTxEmpty` is high. In any other case it is low one cycle later.
- R10: An owned descriptor with count zero reads no memory, clears its ownership flag, advances `nextBuf`, and raises neither `crcReq` nor `bufDoneIrq`.
- R11: Dropping `chanEn` stops any fetch and returns `nextBuf` to 0 on the next cycle. It leaves all descriptor fields, including the ownership flags, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chanEn | input | 1 | Channel enable |
| ienBufDone | input | 1 | Global buffer-done interrupt enable |
| ienTxEmpty | input | 1 | Transmit-empty interrupt enable |
| cpuWe | input | 1 | CPU descriptor write strobe |
| cpuSel | input | 1 | Descriptor select, 0 = A, 1 = B |
| cpuField | input | 2 | 0 address, 1 count, 2 status |
| cpuWdata | input | 32 | Write data (low bits used for count and status) |
| statA | output | 8 | Status byte of descriptor A |
| statB | output | 8 | Status byte of descriptor B |
| nextBuf | output | 1 | Descriptor serviced next |
| memValid | output | 1 | Memory read request |
| memAddr | output | 32 | Byte address of the request |
| memReady | input | 1 | Memory returns `memData` this cycle |
| memData | input | 8 | Read byte |
| fifoPush | output | 1 | FIFO write strobe |
| fifoData | output | 8 | FIFO write byte |
| fifoEof | output | 1 | Byte ends the frame |
| fifoFull | input | 1 | FIFO cannot accept a byte |
| txLineIdle | input | 1 | Framer has nothing left to send |
| crcReq | output | 1 | Append-CRC request pulse |
| bufDoneIrq | output | 1 | Buffer-done interrupt pulse |
| txEmptyIrq | output | 1 | Transmit-empty interrupt |

## Verification
A frame that spans two buffers, with the interrupt flag set on one buffer only, shows whether end-of-frame, CRC request and buffer-done follow the correct buffer and not simply every buffer. Arming B before A checks that ownership is sampled only on the current descriptor. A zero-count buffer and a channel disable in the middle of a stalled fetch cover the paths that leave a buffer without a final byte. Memory ready and FIFO full vary from cycle to cycle, so the byte stream is checked against the computed addresses under back-pressure, not only at full rate.

// File: rtl/txDmaPkg.sv
package txDmaPkg;
  localparam int OWN_BIT = 7;
  localparam int EOF_BIT = 1;
  localparam int INT_BIT = 0;

  localparam logic [1:0] FLD_ADDR = 2'd0;
  localparam logic [1:0] FLD_CNT  = 2'd1;
  localparam logic [1:0] FLD_STAT = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_FETCH = 2'd2
  } seqState_t;

  typedef struct packed {
    logic clrOwn;
    logic sel;
  } descStrobe_t;
endpackage

// File: rtl/txDescBank.sv
module txDescBank
  import txDmaPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int STAT_W = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cpuWe,
  input  logic                          cpuSel,
  input  logic [1:0]                    cpuField,
  input  logic [ADDR_W-1:0]             cpuWdata,
  input  descStrobe_t                   strobe,
  output logic [1:0][ADDR_W-1:0]        descAddr,
  output logic [1:0][CNT_W-1:0]         descCnt,
  output logic [1:0][STAT_W-1:0]        descStat
);
  localparam int NUM_DESC = 2;

  for (genvar g = 0; g < NUM_DESC; g++) begin : gDesc
    logic hit;
    logic release_;
    assign hit      = cpuWe && (cpuSel == 1'(g)) && !descStat[g][OWN_BIT];
    assign release_ = strobe.clrOwn && (strobe.sel == 1'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        descAddr[g] <= '0;
        descCnt[g]  <= '0;
        descStat[g] <= '0;
      end else if (release_) begin
        descStat[g][OWN_BIT] <= 1'b0;
      end else if (hit) begin
        case (cpuField)
          FLD_ADDR: descAddr[g] <= cpuWdata;
          FLD_CNT:  descCnt[g]  <= cpuWdata[CNT_W-1:0];
          FLD_STAT: descStat[g] <= cpuWdata[STAT_W-1:0];
          default:  ;
        endcase
      end
    end

    // R5: ownership only drops when the sequencer releases this descriptor
    a_r5_own_release: assert property (@(posedge clk) disable iff (!rstN)
      $fell(descStat[g][OWN_BIT]) |-> $past(strobe.clrOwn && strobe.sel == 1'(g)));

    // R6: an owned descriptor keeps its address and count
    a_r6_owned_frozen: assert property (@(posedge clk) disable iff (!rstN)
      descStat[g][OWN_BIT] |=> ($stable(descAddr[g]) && $stable(descCnt[g])));
  end
endmodule

// File: rtl/txSeqCtrl.sv
module txSeqCtrl
  import txDmaPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int STAT_W = 8,
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   chanEn,
  input  logic                   ienBufDone,
  input  logic                   ienTxEmpty,
  input  logic [1:0][ADDR_W-1:0] descAddr,
  input  logic [1:0][CNT_W-1:0]  descCnt,
  input  logic [1:0][STAT_W-1:0] descStat,
  output descStrobe_t            strobe,
  output logic                   nextBuf,
  output logic                   memValid,
  output logic [ADDR_W-1:0]      memAddr,
  input  logic                   memReady,
  input  logic [DATA_W-1:0]      memData,
  output logic                   fifoPush,
  output logic [DATA_W-1:0]      fifoData,
  output logic                   fifoEof,
  input  logic                   fifoFull,
  input  logic                   txLineIdle,
  output logic                   crcReq,
  output logic                   bufDoneIrq,
  output logic                   txEmptyIrq
);
  seqState_t          state;
  logic               cur;
  logic [ADDR_W-1:0]  addrQ;
  logic [CNT_W-1:0]   remQ;
  logic [STAT_W-1:0]  curStat;
  logic               curOwn;
  logic               zeroCnt;
  logic               beat;
  logic               lastBeat;

  assign curStat  = descStat[cur];
  assign curOwn   = curStat[OWN_BIT];
  assign zeroCnt  = (descCnt[cur] == '0);
  assign beat     = (state == ST_FETCH) && !fifoFull && memReady;
  assign lastBeat = beat && (remQ == CNT_W'(1));

  always_comb begin
    strobe.sel    = cur;
    strobe.clrOwn = lastBeat || ((state == ST_WAIT) && curOwn && zeroCnt);
  end

  assign nextBuf  = cur;
  assign memValid = (state == ST_FETCH) && !fifoFull;
  assign memAddr  = addrQ;
  assign fifoPush = beat;
  assign fifoData = memData;
  assign fifoEof  = lastBeat && curStat[EOF_BIT];

  always_ff @(posedge clk) begin
    if (!rstN || !chanEn) begin
      state      <= ST_IDLE;
      cur        <= 1'b0;
      crcReq     <= 1'b0;
      bufDoneIrq <= 1'b0;
      txEmptyIrq <= 1'b0;
      if (!rstN) begin
        addrQ <= '0;
        remQ  <= '0;
      end
    end else begin
      crcReq     <= lastBeat && curStat[EOF_BIT];
      bufDoneIrq <= lastBeat && ienBufDone && curStat[INT_BIT];
      txEmptyIrq <= ienTxEmpty && txLineIdle && (state == ST_WAIT);
      case (state)
        ST_IDLE: state <= ST_WAIT;
        ST_WAIT: begin
          if (curOwn) begin
            if (zeroCnt) begin
              cur <= ~cur;
            end else begin
              addrQ <= descAddr[cur];
              remQ  <= descCnt[cur];
              state <= ST_FETCH;
            end
          end
        end
        ST_FETCH: begin
          if (beat) begin
            addrQ <= addrQ + 1'b1;
            remQ  <= remQ - 1'b1;
            if (lastBeat) begin
              cur   <= ~cur;
              state <= ST_WAIT;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: fetching only ever happens on an owned current descriptor
  a_r2_fetch_owned: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FETCH) |-> curOwn);

  // R7: the CRC request follows an end-of-frame push
  a_r7_crc_after_eof: assert property (@(posedge clk) disable iff (!rstN)
    crcReq |-> $past(fifoPush && fifoEof));

  // R8: buffer-done follows a pushed byte
  a_r8_irq_after_push: assert property (@(posedge clk) disable iff (!rstN)
    bufDoneIrq |-> $past(fifoPush));

  // R5: the pointer moves only together with an ownership release
  a_r5_alternate: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(cur) && chanEn && $past(chanEn)) |-> $past(strobe.clrOwn));

  // R11: disabling parks the sequencer on descriptor A
  a_r11_disable: assert property (@(posedge clk) disable iff (!rstN)
    !chanEn |=> ((state == ST_IDLE) && !cur && !memValid));
endmodule

// File: rtl/txDmaSeq.sv
module txDmaSeq
  import txDmaPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int STAT_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chanEn,
  input  logic              ienBufDone,
  input  logic              ienTxEmpty,
  input  logic              cpuWe,
  input  logic              cpuSel,
  input  logic [1:0]        cpuField,
  input  logic [ADDR_W-1:0] cpuWdata,
  output logic [STAT_W-1:0] statA,
  output logic [STAT_W-1:0] statB,
  output logic              nextBuf,
  output logic              memValid,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memReady,
  input  logic [DATA_W-1:0] memData,
  output logic              fifoPush,
  output logic [DATA_W-1:0] fifoData,
  output logic              fifoEof,
  input  logic              fifoFull,
  input  logic              txLineIdle,
  output logic              crcReq,
  output logic              bufDoneIrq,
  output logic              txEmptyIrq
);
  descStrobe_t             strobe;
  logic [1:0][ADDR_W-1:0]  descAddr;
  logic [1:0][CNT_W-1:0]   descCnt;
  logic [1:0][STAT_W-1:0]  descStat;

  txDescBank #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .STAT_W(STAT_W)) uBank (
    .clk(clk), .rstN(rstN), .cpuWe(cpuWe), .cpuSel(cpuSel),
    .cpuField(cpuField), .cpuWdata(cpuWdata), .strobe(strobe),
    .descAddr(descAddr), .descCnt(descCnt), .descStat(descStat)
  );

  txSeqCtrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .STAT_W(STAT_W), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .chanEn(chanEn), .ienBufDone(ienBufDone),
    .ienTxEmpty(ienTxEmpty), .descAddr(descAddr), .descCnt(descCnt),
    .descStat(descStat), .strobe(strobe), .nextBuf(nextBuf),
    .memValid(memValid), .memAddr(memAddr), .memReady(memReady),
    .memData(memData), .fifoPush(fifoPush), .fifoData(fifoData),
    .fifoEof(fifoEof), .fifoFull(fifoFull), .txLineIdle(txLineIdle),
    .crcReq(crcReq), .bufDoneIrq(bufDoneIrq), .txEmptyIrq(txEmptyIrq)
  );

  assign statA = descStat[0];
  assign statB = descStat[1];
endmodule

// File: tb/sim_txDmaSeq.sv
`timescale 1ns/100ps
module sim_txDmaSeq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        chanEn = 1'b0;
  logic        ienBufDone = 1'b1;
  logic        ienTxEmpty = 1'b0;
  logic        cpuWe = 1'b0;
  logic        cpuSel = 1'b0;
  logic [1:0]  cpuField = 2'd0;
  logic [31:0] cpuWdata = '0;
  logic [7:0]  statA, statB;
  logic        nextBuf, memValid, fifoPush, fifoEof, crcReq, bufDoneIrq, txEmptyIrq;
  logic [31:0] memAddr;
  logic        memReady = 1'b0;
  logic [7:0]  memData;
  logic [7:0]  fifoData;
  logic        fifoFull = 1'b0;
  logic        txLineIdle = 1'b0;

  int checks = 0;
  int fails = 0;
  int irqSeen = 0, crcSeen = 0, pushSeen = 0;
  int expIrq = 0, expCrc = 0;
  logic [8:0] expQ[$];
  logic stallRand = 1'b0;
  logic stallForce = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] memByte(logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction
  assign memData = memByte(memAddr);

  txDmaSeq u0 (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // input pattern generator, updated just after each rising edge
  initial forever begin
    @(posedge clk); #1;
    lfsr     <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    memReady <= lfsr[0] | lfsr[3];
    fifoFull <= stallForce | (stallRand & lfsr[5] & lfsr[7]);
  end

  // monitor / scoreboard
  initial forever begin
    @(negedge clk);
    if (rstN) begin
      if (fifoFull) check(!memValid, "R4", "memValid under fifoFull", memValid, 0);
      if (crcReq) crcSeen++;
      if (bufDoneIrq) irqSeen++;
      if (fifoPush) begin
        pushSeen++;
        if (expQ.size() == 0) begin
          check(0, "R2", "unexpected push", {23'd0, fifoEof, fifoData}, 0);
        end else begin
          logic [8:0] e;
          e = expQ.pop_front();
          check({fifoEof, fifoData} == e, "R3", "byte/eof", {fifoEof, fifoData}, e);
        end
      end
    end
  end

  task automatic cpuWrite(input logic sel, input logic [1:0] fld, input logic [31:0] d);
    @(negedge clk);
    cpuWe = 1'b1; cpuSel = sel; cpuField = fld; cpuWdata = d;
    @(negedge clk);
    cpuWe = 1'b0;
  endtask

  task automatic addBytes(input logic [31:0] base, input int n, input bit eof);
    for (int i = 0; i < n; i++)
      expQ.push_back({(eof && i == n - 1), memByte(base + 32'(i))});
  endtask

  task automatic giveBuf(input logic sel, input logic [31:0] base, input int n,
                         input bit eof, input bit intr, input bit enq);
    cpuWrite(sel, 2'd0, base);
    cpuWrite(sel, 2'd1, 32'(n));
    if (enq) begin
      addBytes(base, n, eof);
      if (n > 0 && eof) expCrc++;
      if (n > 0 && intr && ienBufDone) expIrq++;
    end
    cpuWrite(sel, 2'd2, {24'd0, 1'b1, 5'd0, eof, intr});
  endtask

  task automatic drain(input string req);
    int t = 0;
    while (expQ.size() != 0 && t < 4000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, req, "all bytes delivered", expQ.size(), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(statA == 0 && statB == 0, "R1", "status after reset", {statA, statB}, 0);
    check(nextBuf == 0, "R1", "nextBuf after reset", nextBuf, 0);
    check(!memValid && !fifoPush && !crcReq && !bufDoneIrq && !txEmptyIrq,
          "R1", "outputs idle", {memValid, fifoPush, crcReq, bufDoneIrq, txEmptyIrq}, 0);

    chanEn = 1'b1;
    stallRand = 1'b1;
    // R2: B armed first must be ignored while A is current
    giveBuf(1'b1, 32'h0000_2100, 3, 1'b1, 1'b0, 1'b0);
    repeat (20) @(negedge clk);
    check(pushSeen == 0, "R2", "no fetch while A not owned", pushSeen, 0);
    check(nextBuf == 0, "R2", "still waiting on A", nextBuf, 0);
    // two-buffer frame A (no EOF, intr) then B (EOF, no intr)
    giveBuf(1'b0, 32'h0000_10FE, 5, 1'b0, 1'b1, 1'b1);
    addBytes(32'h0000_2100, 3, 1'b1);
    expCrc++;
    drain("R3");
    check(statA[7] == 0 && statB[7] == 0, "R5", "ownership released", {statA, statB}, 0);
    check(nextBuf == 0, "R5", "alternated back to A", nextBuf, 0);
    check(crcSeen == expCrc, "R7", "crc only after EOF buffer", crcSeen, expCrc);
    check(irqSeen == expIrq, "R8", "irq only for flagged buffer", irqSeen, expIrq);

    // R6: writes to owned B ignored
    giveBuf(1'b1, 32'h0000_2000, 2, 1'b1, 1'b1, 1'b0);
    cpuWrite(1'b1, 2'd0, 32'h0000_9999);
    cpuWrite(1'b1, 2'd2, 32'h0000_0000);
    @(negedge clk);
    check(statB == 8'h83, "R6", "owned status unchanged", statB, 8'h83);
    giveBuf(1'b0, 32'h0000_1800, 2, 1'b0, 1'b0, 1'b1);
    addBytes(32'h0000_2000, 2, 1'b1);
    expCrc++; expIrq++;
    drain("R6");
    check(nextBuf == 0, "R5", "nextBuf after A,B", nextBuf, 0);
    check(crcSeen == expCrc && irqSeen == expIrq, "R8", "crc/irq totals",
          {crcSeen[15:0], irqSeen[15:0]}, {expCrc[15:0], expIrq[15:0]});

    // R10 zero count
    stallRand = 1'b0;
    giveBuf(1'b0, 32'h0000_5000, 0, 1'b1, 1'b1, 1'b0);
    repeat (4) @(negedge clk);
    check(statA[7] == 0, "R10", "zero-count released", statA, 8'h03);
    check(nextBuf == 1, "R10", "advanced to B", nextBuf, 1);
    check(crcSeen == expCrc && irqSeen == expIrq, "R10", "no crc/irq on zero count",
          {crcSeen[15:0], irqSeen[15:0]}, {expCrc[15:0], expIrq[15:0]});

    // R9 transmit-empty
    ienTxEmpty = 1'b1; txLineIdle = 1'b1;
    repeat (2) @(negedge clk);
    check(txEmptyIrq == 1, "R9", "empty irq while waiting", txEmptyIrq, 1);
    txLineIdle = 1'b0;
    repeat (2) @(negedge clk);
    check(txEmptyIrq == 0, "R9", "empty irq clears", txEmptyIrq, 0);
    ienTxEmpty = 1'b0;

    // R11 disable mid-fetch on B
    stallForce = 1'b1;
    giveBuf(1'b1, 32'h0000_3000, 4, 1'b1, 1'b1, 1'b0);
    repeat (5) @(negedge clk);
    check(pushSeen > 0 && !memValid, "R4", "stalled fetch", memValid, 0);
    chanEn = 1'b0;
    repeat (2) @(negedge clk);
    check(nextBuf == 0, "R11", "pointer back to A", nextBuf, 0);
    check(statB == 8'h83, "R11", "descriptor kept", statB, 8'h83);
    stallForce = 1'b0;
    chanEn = 1'b1;
    repeat (10) @(negedge clk);
    check(statB[7] == 1, "R11", "B not serviced before A", statB, 8'h83);
    giveBuf(1'b0, 32'h0000_4000, 3, 1'b0, 1'b0, 1'b1);
    addBytes(32'h0000_3000, 4, 1'b1);
    expCrc++; expIrq++;
    drain("R11");
    check(statA[7] == 0 && statB[7] == 0, "R5", "final release", {statA, statB}, 0);
    check(crcSeen == expCrc, "R7", "final crc count", crcSeen, expCrc);
    check(irqSeen == expIrq, "R8", "final irq count", irqSeen, expIrq);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule